// File: doc/BRIEF.md
# Command Packet Fetch Engine

This block sits between a tape controller's register front end and its command execution core. When software posts a command pointer, the engine reads the command packet out of host memory one 16-bit word at a time over a simple request/acknowledge read port. It first reads the header word and looks up the command code, through a small external table, to learn whether the code is supported and how long its packet is. It then reads the remaining words and assembles the data pointer and the byte/record/file count. Finally it either hands one decoded command to the execution core or rejects the packet with a termination class.

The engine enforces the start-up interlock. After reset no message-buffer address is known, so every command except write-characteristics is refused. The first accepted write-characteristics command lifts the interlock. A read that is neither acknowledged nor refused within a time limit is treated as a nonexistent-memory access. The engine abandons the packet and returns to idle.

Top module: `cmd_packet_fetch`

## Requirements
- R1: After reset `ready_o` is 1, `need_buf_o` is 1, `nxm_o` and `sc_o` are 0, and no read, command or reject is issued.
- R2: The packet base is `ptr_addr_i` with its two low bits forced to zero. Packet word k is read at base + 2k, in increasing order, and the header (k = 0) is always read first.
- R3: `lut_len_i` gives the packet length for the header code presented on `lut_code_o` (header bits 4:0): 2'b00 means 1 word, 2'b01 means 2 words and 2'b10 means 4 words. Exactly that many words are read.
- R4: `cmd_count_o` is word 1 of a 2-word packet, word 3 of a 4-word packet, and 0 for a 1-word packet. `cmd_word_o` is the header. `cmd_is_data_o` is 1 only for 4-word packets.
- R5: With `ext_mode_i` = 0, `cmd_ptr_o` is {high word bits 1:0, low word}, where the low word is packet word 1 and the high word is packet word 2. Bits 21:18 are zero, and high-word bits 15:2 have no effect.
- R6: With `ext_mode_i` = 1, `cmd_ptr_o` bits 21:18 are taken from high-word bits 5:2, and the rest is as in R5.
- R7: While `need_buf_o` is 1, a header whose `lut_wchar_i` is 0 is rejected with `rej_class_o` = 3 after only the header read. A completed write-characteristics command clears `need_buf_o`.
- R8: A header with `lut_unsup_i` = 1 or `lut_len_i` = 2'b11 is rejected with class 3 after only the header read.
- R9: A read left unanswered for TIMEOUT_US microseconds at CLK_MHZ sets `nxm_o` and `sc_o`. The engine then issues no command or reject and returns to ready.
- R10: A read answered with `mem_err_i` has the same effect as a timeout.
- R11: `mem_req_o` stays asserted with a stable `mem_addr_o` until that read is acknowledged, refused or timed out.
- R12: Each accepted pointer produces at most one outcome (command, reject or nxm abort), after which `ready_o` returns to 1. `ptr_valid_i` is ignored while `ready_o` is 0.
- R13: `sc_o` is set by a reject or an nxm abort and cleared when the next pointer is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ext_mode_i | input | 1 | Extended (22-bit) pointer interpretation |
| ptr_valid_i | input | 1 | Command pointer posted |
| ptr_addr_i | input | AW | Posted command pointer (byte address) |
| ready_o | output | 1 | Engine idle, pointer can be accepted |
| mem_req_o | output | 1 | Host read request |
| mem_addr_o | output | AW | Host read byte address |
| mem_rdata_i | input | DW | Host read data |
| mem_ack_i | input | 1 | Read completed, data valid |
| mem_err_i | input | 1 | Read refused by host |
| lut_code_o | output | CODE_W | Header command code to lookup |
| lut_len_i | input | 2 | Packet length code for lut_code_o |
| lut_unsup_i | input | 1 | Code is unsupported |
| lut_wchar_i | input | 1 | Code is write-characteristics |
| cmd_valid_o | output | 1 | One-cycle decoded command strobe |
| cmd_word_o | output | DW | Header word |
| cmd_ptr_o | output | AW | Assembled data pointer |
| cmd_count_o | output | DW | Byte/record/file count |
| cmd_is_data_o | output | 1 | Packet carried a data pointer |
| rej_valid_o | output | 1 | One-cycle reject strobe |
| rej_class_o | output | 3 | Termination class of reject |
| need_buf_o | output | 1 | Buffer-address interlock active |
| nxm_o | output | 1 | Nonexistent-memory flag |
| sc_o | output | 1 | Special-condition flag |

## Verification
The properties assume that the host never asserts `mem_ack_i` or `mem_err_i` while no read is requested. They also assume that the lookup answers combinationally and stays stable while the header code on `lut_code_o` is unchanged. The stimulus keeps to these assumptions. The bench's memory responder answers only while it sees `mem_req_o` high, and it answers with a chosen latency or not at all. The lookup table is a pure function of the presented code. `ext_mode_i` is changed only while the engine is idle.

// File: rtl/cpf_pkg.sv
package cpf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_DECODE = 2'd2,
        ST_ISSUE = 2'd3
    } cpf_state_e;

    typedef enum logic [2:0] {
        TC_NORMAL     = 3'd0,
        TC_ATTENTION  = 3'd1,
        TC_TAPE_ALERT = 3'd2,
        TC_REJECT     = 3'd3,
        TC_RECOV_MOVE = 3'd4,
        TC_RECOV_STAY = 3'd5,
        TC_POS_LOST   = 3'd6,
        TC_FATAL      = 3'd7
    } term_class_e;

    localparam logic [1:0] LEN_ONE  = 2'b00;
    localparam logic [1:0] LEN_TWO  = 2'b01;
    localparam logic [1:0] LEN_FOUR = 2'b10;
    localparam logic [1:0] LEN_BAD  = 2'b11;

endpackage

// File: rtl/cpf_timeout.sv
module cpf_timeout #(
    parameter int CLK_MHZ    = 250,
    parameter int TIMEOUT_US = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic restart_i,
    output logic expired_o
);
    localparam int LIMIT = CLK_MHZ * TIMEOUT_US;
    localparam int TW    = $clog2(LIMIT + 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!run_i || restart_i) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = run_i && (cnt_q == TW'(LIMIT - 1));

endmodule

// File: rtl/cpf_ptr_asm.sv
module cpf_ptr_asm #(
    parameter int AW = 22,
    parameter int DW = 16
) (
    input  logic [DW-1:0] lo_i,
    input  logic [DW-1:0] hi_i,
    input  logic          ext_i,
    output logic [AW-1:0] ptr_o
);
    localparam int STD_W = 18;
    localparam int EXT_W = 22;

    logic [EXT_W-1:0] full;
    logic [3:0]       upper;

    assign upper = ext_i ? hi_i[5:2] : 4'b0000;
    assign full  = {upper, hi_i[1:0], lo_i[15:0]};

    generate
        if (AW >= EXT_W) begin : g_wide
            assign ptr_o = AW'(full);
        end else if (AW >= STD_W) begin : g_mid
            assign ptr_o = full[AW-1:0];
        end else begin : g_narrow
            assign ptr_o = full[AW-1:0];
        end
    endgenerate

endmodule

// File: rtl/cmd_packet_fetch.sv
module cmd_packet_fetch
    import cpf_pkg::*;
#(
    parameter int AW         = 22,
    parameter int DW         = 16,
    parameter int CODE_W     = 5,
    parameter int CLK_MHZ    = 250,
    parameter int TIMEOUT_US = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_mode_i,
    input  logic              ptr_valid_i,
    input  logic [AW-1:0]     ptr_addr_i,
    output logic              ready_o,
    output logic              mem_req_o,
    output logic [AW-1:0]     mem_addr_o,
    input  logic [DW-1:0]     mem_rdata_i,
    input  logic              mem_ack_i,
    input  logic              mem_err_i,
    output logic [CODE_W-1:0] lut_code_o,
    input  logic [1:0]        lut_len_i,
    input  logic              lut_unsup_i,
    input  logic              lut_wchar_i,
    output logic              cmd_valid_o,
    output logic [DW-1:0]     cmd_word_o,
    output logic [AW-1:0]     cmd_ptr_o,
    output logic [DW-1:0]     cmd_count_o,
    output logic              cmd_is_data_o,
    output logic              rej_valid_o,
    output logic [2:0]        rej_class_o,
    output logic              need_buf_o,
    output logic              nxm_o,
    output logic              sc_o
);
    localparam int NWORDS = 4;
    localparam int IW     = $clog2(NWORDS);

    typedef struct packed {
        cpf_state_e               st;
        logic [AW-1:0]            base;
        logic [IW-1:0]            idx;
        logic [IW-1:0]            last;
        logic [NWORDS-1:0][DW-1:0] words;
        logic                     need_buf;
        logic                     nxm;
        logic                     sc;
    } regs_t;

    regs_t r_d, r_q;

    logic expired;
    logic in_read;
    logic reject;

    assign in_read = (r_q.st == ST_READ);

    cpf_timeout #(
        .CLK_MHZ   (CLK_MHZ),
        .TIMEOUT_US(TIMEOUT_US)
    ) u_timeout (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (in_read),
        .restart_i(in_read && mem_ack_i),
        .expired_o(expired)
    );

    cpf_ptr_asm #(
        .AW(AW),
        .DW(DW)
    ) u_ptr_asm (
        .lo_i (r_q.words[1]),
        .hi_i (r_q.words[2]),
        .ext_i(ext_mode_i),
        .ptr_o(cmd_ptr_o)
    );

    assign lut_code_o = r_q.words[0][CODE_W-1:0];
    assign reject = lut_unsup_i || (lut_len_i == LEN_BAD)
                    || (r_q.need_buf && !lut_wchar_i);

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (ptr_valid_i) begin
                    r_d.st   = ST_READ;
                    r_d.base = {ptr_addr_i[AW-1:2], 2'b00};
                    r_d.idx  = '0;
                    r_d.last = '0;
                    r_d.nxm  = 1'b0;
                    r_d.sc   = 1'b0;
                end
            end
            ST_READ: begin
                if (mem_ack_i && !mem_err_i) begin
                    r_d.words[r_q.idx] = mem_rdata_i;
                    if (r_q.idx == '0) begin
                        r_d.st = ST_DECODE;
                    end else if (r_q.idx == r_q.last) begin
                        r_d.st = ST_ISSUE;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                    end
                end else if (mem_err_i || expired) begin
                    r_d.nxm = 1'b1;
                    r_d.sc  = 1'b1;
                    r_d.st  = ST_IDLE;
                end
            end
            ST_DECODE: begin
                if (reject) begin
                    r_d.sc = 1'b1;
                    r_d.st = ST_IDLE;
                end else if (lut_len_i == LEN_ONE) begin
                    r_d.last = '0;
                    r_d.st   = ST_ISSUE;
                end else begin
                    r_d.idx  = IW'(1);
                    r_d.last = (lut_len_i == LEN_TWO) ? IW'(1) : IW'(3);
                    r_d.st   = ST_READ;
                end
            end
            ST_ISSUE: begin
                if (lut_wchar_i) begin
                    r_d.need_buf = 1'b0;
                end
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.st       <= ST_IDLE;
            r_q.need_buf <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign ready_o       = (r_q.st == ST_IDLE);
    assign mem_req_o     = in_read;
    assign mem_addr_o    = r_q.base + AW'({r_q.idx, 1'b0});
    assign cmd_valid_o   = (r_q.st == ST_ISSUE);
    assign cmd_word_o    = r_q.words[0];
    assign cmd_is_data_o = (r_q.last == IW'(3));
    assign cmd_count_o   = (r_q.last == IW'(3)) ? r_q.words[3] :
                           (r_q.last == IW'(1)) ? r_q.words[1] : '0;
    assign rej_valid_o   = (r_q.st == ST_DECODE) && reject;
    assign rej_class_o   = TC_REJECT;
    assign need_buf_o    = r_q.need_buf;
    assign nxm_o         = r_q.nxm;
    assign sc_o          = r_q.sc;

endmodule

// File: rtl/cpf_checker.sv
module cpf_checker #(
    parameter int AW = 22
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ready_o,
    input logic          mem_req_o,
    input logic [AW-1:0] mem_addr_o,
    input logic          mem_ack_i,
    input logic          mem_err_i,
    input logic          cmd_valid_o,
    input logic          rej_valid_o,
    input logic [2:0]    rej_class_o,
    input logic          nxm_o,
    input logic          sc_o
);
    // R11: an outstanding read keeps its address until answered or timed out
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i && !mem_err_i)
        |=> ((mem_req_o && $stable(mem_addr_o)) || $rose(nxm_o)));

    // R2: read addresses are word aligned
    p_addr_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (mem_addr_o[0] == 1'b0));

    // R12: at most one outcome, then idle
    p_one_outcome_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid_o && rej_valid_o));

    p_back_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o || rej_valid_o) |=> ready_o);

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> !(mem_req_o || cmd_valid_o || rej_valid_o));

    // R7 / R8: rejects carry function-reject class
    p_rej_class_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rej_valid_o |-> (rej_class_o == 3'd3));

    // R9: nxm abort raises special condition and lands in idle
    p_nxm_sc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nxm_o) |-> (sc_o && ready_o));

    // R13: a reject raises special condition
    p_rej_sc_r13: assert property (@(posedge clk) disable iff (!rst_n)
        rej_valid_o |=> sc_o);

endmodule

bind cmd_packet_fetch cpf_checker #(.AW(AW)) u_cpf_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .ready_o    (ready_o),
    .mem_req_o  (mem_req_o),
    .mem_addr_o (mem_addr_o),
    .mem_ack_i  (mem_ack_i),
    .mem_err_i  (mem_err_i),
    .cmd_valid_o(cmd_valid_o),
    .rej_valid_o(rej_valid_o),
    .rej_class_o(rej_class_o),
    .nxm_o      (nxm_o),
    .sc_o       (sc_o)
);

// File: tb/cmd_packet_fetch_bench.sv
`timescale 1ns/1ps
module cmd_packet_fetch_bench;
    localparam int AW = 22;
    localparam int DW = 16;
    localparam int TO_CYC = 250 * 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ext_mode_i = 1'b0;
    logic          ptr_valid_i = 1'b0;
    logic [AW-1:0] ptr_addr_i = '0;
    logic          ready_o, mem_req_o;
    logic [AW-1:0] mem_addr_o;
    logic [DW-1:0] mem_rdata_i = '0;
    logic          mem_ack_i = 1'b0, mem_err_i = 1'b0;
    logic [4:0]    lut_code_o;
    logic [1:0]    lut_len_i;
    logic          lut_unsup_i, lut_wchar_i;
    logic          cmd_valid_o, cmd_is_data_o, rej_valid_o;
    logic [DW-1:0] cmd_word_o, cmd_count_o;
    logic [AW-1:0] cmd_ptr_o;
    logic [2:0]    rej_class_o;
    logic          need_buf_o, nxm_o, sc_o;

    always #2 clk = ~clk;

    cmd_packet_fetch u_cmd_packet_fetch (
        .clk(clk), .rst_n(rst_n), .ext_mode_i(ext_mode_i),
        .ptr_valid_i(ptr_valid_i), .ptr_addr_i(ptr_addr_i), .ready_o(ready_o),
        .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i),
        .mem_ack_i(mem_ack_i), .mem_err_i(mem_err_i), .lut_code_o(lut_code_o),
        .lut_len_i(lut_len_i), .lut_unsup_i(lut_unsup_i), .lut_wchar_i(lut_wchar_i),
        .cmd_valid_o(cmd_valid_o), .cmd_word_o(cmd_word_o), .cmd_ptr_o(cmd_ptr_o),
        .cmd_count_o(cmd_count_o), .cmd_is_data_o(cmd_is_data_o),
        .rej_valid_o(rej_valid_o), .rej_class_o(rej_class_o),
        .need_buf_o(need_buf_o), .nxm_o(nxm_o), .sc_o(sc_o)
    );

    int checks = 0;
    int failures = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // lookup table: 2 -> 1 word, 3 -> 2 words, 4 -> write-char 4 words,
    // 5 -> data 4 words, 7 -> unsupported, 9 -> bad length code
    function automatic int words_for(input int code);
        case (code)
            2: return 1;
            3: return 2;
            4, 5: return 4;
            default: return 0;
        endcase
    endfunction

    always_comb begin
        lut_unsup_i = (lut_code_o == 5'd7);
        lut_wchar_i = (lut_code_o == 5'd4);
        case (lut_code_o)
            5'd2: lut_len_i = 2'b00;
            5'd3: lut_len_i = 2'b01;
            5'd4, 5'd5: lut_len_i = 2'b10;
            5'd9: lut_len_i = 2'b11;
            default: lut_len_i = 2'b00;
        endcase
    end

    // behavioural host memory and responder
    logic [15:0] mem [int];
    int exp_addr [$];
    int resp_lat = 0;
    int resp_mode = 0;   // 0 answer, 1 refuse, 2 silent
    int resp_cnt = 0;

    initial begin
        forever begin
            @(negedge clk);
            mem_ack_i = 1'b0;
            mem_err_i = 1'b0;
            if (mem_req_o && resp_mode != 2) begin
                if (resp_cnt >= resp_lat) begin
                    resp_cnt = 0;
                    if (exp_addr.size() == 0) begin
                        chk(1'b0, "R2 unexpected read", mem_addr_o, 0);
                    end else begin
                        int e;
                        e = exp_addr.pop_front();
                        chk(int'(mem_addr_o) == e, "R2 read address", mem_addr_o, e);
                    end
                    if (resp_mode == 1) begin
                        mem_err_i = 1'b1;
                    end else begin
                        mem_ack_i = 1'b1;
                        mem_rdata_i = mem.exists(int'(mem_addr_o)) ? mem[int'(mem_addr_o)] : 16'h0;
                    end
                end else begin
                    resp_cnt++;
                end
            end else begin
                resp_cnt = 0;
            end
        end
    end

    int cyc = 0;
    bit wd_hit = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !wd_hit) begin
            wd_hit = 1;
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    bit need_buf_m = 1;

    task automatic put(input int a, input int w0, input int w1, input int w2, input int w3);
        mem[a] = 16'(w0); mem[a+2] = 16'(w1); mem[a+4] = 16'(w2); mem[a+6] = 16'(w3);
    endtask

    // outcome: 1 command, 2 reject, 3 nxm abort
    task automatic run(input int ptr, input int lat, input int mode, input bit hold,
                       input string tag);
        int base, code, n, expo, got, waited, cnt_e;
        longint ptr_e;
        bit wc;
        base = ptr & ~3;
        code = mem[base] & 31;
        n = words_for(code);
        wc = (code == 4);
        exp_addr.delete();
        resp_lat = lat;
        resp_mode = mode;
        if (mode != 0) begin
            expo = 3;
            exp_addr.push_back(base);
        end else if (n == 0 || (need_buf_m && !wc)) begin
            expo = 2;
            exp_addr.push_back(base);
        end else begin
            expo = 1;
            for (int k = 0; k < n; k++) exp_addr.push_back(base + 2 * k);
        end
        cnt_e = (n == 4) ? int'(mem[base+6]) : (n == 2) ? int'(mem[base+2]) : 0;
        ptr_e = ((ext_mode_i ? longint'((mem[base+4] >> 2) & 15) : 0) << 18)
              | (longint'(mem[base+4] & 3) << 16) | longint'(mem[base+2]);
        @(negedge clk);
        ptr_valid_i = 1'b1;
        ptr_addr_i = AW'(ptr);
        @(negedge clk);
        if (hold) ptr_addr_i = AW'(ptr + 'h100);
        else ptr_valid_i = 1'b0;
        got = 0;
        waited = 0;
        while (got == 0 && waited < 8000) begin
            if (cmd_valid_o) got = 1;
            else if (rej_valid_o) got = 2;
            else if (ready_o && nxm_o) got = 3;
            if (got == 0) begin
                @(negedge clk);
                waited++;
            end
        end
        ptr_valid_i = 1'b0;
        chk(got == expo, {tag, " outcome"}, got, expo);
        if (got == 1) begin
            chk(cmd_word_o == mem[base], {tag, " R4 header"}, cmd_word_o, mem[base]);
            chk(int'(cmd_count_o) == cnt_e, {tag, " R4 count"}, cmd_count_o, cnt_e);
            chk(cmd_is_data_o == (n == 4), {tag, " R4 data flag"}, cmd_is_data_o, n == 4);
            if (n == 4)
                chk(longint'(cmd_ptr_o) == ptr_e, {tag, " R5/R6 pointer"}, cmd_ptr_o, ptr_e);
            chk(sc_o == 1'b0, {tag, " R13 sc clear"}, sc_o, 0);
            if (wc) need_buf_m = 0;
        end else if (got == 2) begin
            chk(rej_class_o == 3'd3, {tag, " R7 class"}, rej_class_o, 3);
        end else if (got == 3) begin
            if (mode == 2)
                chk(waited >= TO_CYC && waited <= TO_CYC + 3, {tag, " R9 limit"}, waited, TO_CYC);
            chk(sc_o == 1'b1, {tag, " R9 sc"}, sc_o, 1);
        end
        @(negedge clk);
        chk(ready_o && !mem_req_o, {tag, " R12 back to ready"}, ready_o, 1);
        if (got == 2) chk(sc_o == 1'b1, {tag, " R13 sc after reject"}, sc_o, 1);
        chk(need_buf_o == need_buf_m, {tag, " R7 interlock"}, need_buf_o, need_buf_m);
        if (mode != 2)
            chk(exp_addr.size() == 0, {tag, " R3 word count"}, exp_addr.size(), 0);
        chk(nxm_o == (expo == 3), {tag, " R9 nxm flag"}, nxm_o, expo == 3);
        exp_addr.delete();
        resp_mode = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(ready_o == 1'b1, "R1 ready", ready_o, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready_o && need_buf_o && !nxm_o && !sc_o, "R1 reset state",
            {ready_o, need_buf_o, nxm_o, sc_o}, 4'b1100);
        chk(!mem_req_o && !cmd_valid_o && !rej_valid_o, "R1 quiet", mem_req_o, 0);

        put('h100, 'h0005, 'h1111, 'h0001, 'h0020);
        put('h200, 'h0004, 'h1234, 'h0003, 'h0040);
        put('h300, 'h0A02, 'hFFFF, 'hFFFF, 'hFFFF);
        put('h400, 'h0003, 'h0007, 'hEEEE, 'hEEEE);
        put('h500, 'h0105, 'hABCE, 'h003D, 'h0200);
        put('h600, 'h0007, 'h1, 'h2, 'h3);
        put('h700, 'h0009, 'h1, 'h2, 'h3);
        put('h800, 'h0002, 'h0, 'h0, 'h0);
        put('h900, 'h0003, 'h5, 'h0, 'h0);
        put('hA00, 'h0003, 'h0033, 'h0, 'h0);
        put('hB00, 'h0002, 'h0, 'h0, 'h0);

        run('h100, 0, 0, 0, "R7 interlock reject");
        run('h200, 1, 0, 0, "R7 write-char");
        run('h100, 0, 0, 0, "R5 data after interlock");
        run('h300, 0, 0, 0, "R3 one word");
        run('h403, 2, 0, 0, "R2 unaligned two word");
        run('h500, 3, 0, 0, "R5 R11 standard pointer");
        @(negedge clk); ext_mode_i = 1'b1;
        run('h500, 1, 0, 0, "R6 extended pointer");
        @(negedge clk); ext_mode_i = 1'b0;
        run('h600, 0, 0, 0, "R8 unsupported");
        run('h700, 0, 0, 0, "R8 bad length");
        run('h300, 0, 0, 0, "R13 sc cleared");
        run('h800, 0, 2, 0, "R9 timeout");
        run('h900, 0, 1, 0, "R10 refused read");
        run('hA00, 1, 0, 1, "R12 busy pointer ignored");
        run('hA00, 0, 0, 0, "R3 after abort");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule